// File: doc/BRIEF.md
# Three-Phase Instruction Control Unit

This block steers the datapath of a small 32-bit register machine. It reads a 32-bit instruction word from the memory data input and runs every instruction through three equal clock periods: fetch, decode and execute. The word is captured into an internal instruction register when fetch ends. From that register the block drives the register-file read and write addresses, the read and write enables, the ALU operation code, the select of the datapath input multiplexer, a zero-extended immediate and an output enable.

Four instructions are recognised: move-immediate, move-register, add-register and add-immediate. Any other opcode runs through the same three periods but asserts no enable. The program counter, memory timing, register file and ALU sit outside this block.

Top module: `ctl_unit`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge puts the sequencer in fetch. While in fetch, `rd_en_a`, `rd_en_b` and `wr_en` are all low.
- R2: After fetch comes decode, then execute, then fetch again. Each phase lasts exactly one clock period.
- R3: Field layout of the word: opcode in bits 31:26, destination register in bits 25:22, immediate in bits 21:0, source register in bits 21:18.
- R4: Opcode 0x00 (move-immediate) drives the following. `imm_out` is the immediate zero-extended to 32 bits. `wr_addr` is the destination. `alu_op` is 0 (pass). `mux_sel` is 0 (immediate). No read enable is asserted.
- R5: Opcode 0x01 (move-register) drives the following. `rd_addr_b` is the source and `rd_en_b` is high. `wr_addr` is the destination. `alu_op` is 0. `mux_sel` is 1 (register port B).
- R6: Opcode 0x02 (add-register) drives the following. `rd_addr_a` is the destination and `rd_addr_b` is the source, with both read enables high. `wr_addr` is the destination. `alu_op` is 1 (sum). `mux_sel` is 2 (ALU).
- R7: Opcode 0x03 (add-immediate) drives the following. `imm_out` is the zero-extended immediate. `rd_addr_a` is the destination and `rd_en_a` is high. `wr_addr` is the destination. `alu_op` is 1. `mux_sel` is 2.
- R8: For a known opcode, `wr_en` is high for exactly the one execute period and is low again once the next fetch begins.
- R9: Read enables are asserted only in decode and execute, never in fetch.
- R10: The instruction is latched at the end of fetch. Changes on `mem_word` during decode and execute do not affect the outputs. All controls are identical in decode and execute.
- R11: An unknown opcode (0x04 to 0x3F) asserts no enable. It drives all addresses, `alu_op`, `mux_sel` and `imm_out` to 0, and the sequencer still returns to fetch after execute.
- R12: `out_en` is always 0 (disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_word | input | 32 | Instruction word from memory |
| rd_addr_a | output | 4 | Register-file read address A |
| rd_addr_b | output | 4 | Register-file read address B |
| wr_addr | output | 4 | Register-file write address |
| rd_en_a | output | 1 | Read enable A |
| rd_en_b | output | 1 | Read enable B |
| wr_en | output | 1 | Register-file write enable |
| alu_op | output | 2 | ALU operation (0 pass, 1 sum) |
| mux_sel | output | 2 | Datapath input select (0 imm, 1 port B, 2 ALU) |
| imm_out | output | 32 | Zero-extended immediate |
| out_en | output | 1 | Datapath output enable (0 disabled) |

## Verification
Two functions can fall in the same cycle: the end of fetch, when the instruction register loads, and a synchronous reset. Either of them can also meet a change on `mem_word` in the same cycle. The bench provokes the first case by asserting reset during decode and holding it across the edge that would have ended an instruction. It then checks that fetch follows, that no write pulse appears, and that the word present on the edge after reset is released is the one that gets decoded. It also flips `mem_word` one cycle after every fetch edge and checks that the decode and execute outputs keep the latched instruction.

// File: rtl/ctl_pkg.sv
// Package: shared widths, opcode values and control encodings for the
// three-phase control unit. Assumes a fixed 32-bit instruction layout.
package ctl_pkg;
    localparam int DATA_W = 32;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 4;
    localparam int IMM_W  = 22;
    localparam int INSTR_W = OPC_W + REG_W + IMM_W;
    localparam int ALU_W  = 2;
    localparam int MUX_W  = 2;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

    localparam logic [OPC_W-1:0] OP_MOVI = 6'h00;
    localparam logic [OPC_W-1:0] OP_MOVR = 6'h01;
    localparam logic [OPC_W-1:0] OP_ADDR = 6'h02;
    localparam logic [OPC_W-1:0] OP_ADDI = 6'h03;

    localparam logic [ALU_W-1:0] ALU_PASS = 2'd0;
    localparam logic [ALU_W-1:0] ALU_SUM  = 2'd1;

    localparam logic [MUX_W-1:0] SRC_IMM  = 2'd0;
    localparam logic [MUX_W-1:0] SRC_PORTB = 2'd1;
    localparam logic [MUX_W-1:0] SRC_ALU  = 2'd2;
endpackage

// File: rtl/ctl_sequencer.sv
// Module: ctl_sequencer
// Steps fetch -> decode -> execute -> fetch, one clock period per phase.
// Assumes a synchronous active-low reset that forces fetch.
module ctl_sequencer
    import ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase
);
    // Phase register: advances once per clock, wraps from execute to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_FETCH;
        end else begin
            case (phase)
                PH_FETCH:  phase <= PH_DECODE;
                PH_DECODE: phase <= PH_EXEC;
                default:   phase <= PH_FETCH;
            endcase
        end
    end

    // R1: reset lands in fetch
    a_r1_reset_fetch: assert property (@(posedge clk) !rst_n |=> phase == PH_FETCH);
    // R2: phase order
    a_r2_fetch_decode: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FETCH |=> phase == PH_DECODE);
    a_r2_decode_exec: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_DECODE |=> phase == PH_EXEC);
    a_r2_exec_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_EXEC |=> phase == PH_FETCH);
endmodule

// File: rtl/ctl_ireg.sv
// Module: ctl_ireg
// Instruction register: captures the memory word on the edge that ends fetch.
// Assumes the phase input comes from ctl_sequencer.
module ctl_ireg
    import ctl_pkg::*;
#(
    parameter int W = INSTR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_e       phase,
    input  logic [W-1:0] mem_word,
    output logic [W-1:0] instr
);
    // Capture the word only while in fetch; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr <= '0;
        end else if (phase == PH_FETCH) begin
            instr <= mem_word;
        end
    end

    // R10: held through decode into execute and into the next fetch
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_FETCH |=> $stable(instr));
endmodule

// File: rtl/ctl_decode.sv
// Module: ctl_decode
// Splits the latched word into fields and generates datapath controls.
// Data-type controls follow the word; enables are gated by the phase.
// Assumes the word is stable from decode through execute.
module ctl_decode
    import ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase,
    input  logic [INSTR_W-1:0] instr,
    output logic [REG_W-1:0]   rd_addr_a,
    output logic [REG_W-1:0]   rd_addr_b,
    output logic [REG_W-1:0]   wr_addr,
    output logic               rd_en_a,
    output logic               rd_en_b,
    output logic               wr_en,
    output logic [ALU_W-1:0]   alu_op,
    output logic [MUX_W-1:0]   mux_sel,
    output logic [DATA_W-1:0]  imm_out,
    output logic               out_en
);
    localparam int DST_LSB = IMM_W;
    localparam int SRC_LSB = IMM_W - REG_W;

    logic [OPC_W-1:0]  opc;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src;
    logic [DATA_W-1:0] imm_ext;
    logic              active;
    logic              in_exec;

    // Field split per the fixed layout (R3).
    assign opc     = instr[INSTR_W-1 -: OPC_W];
    assign dst     = instr[DST_LSB +: REG_W];
    assign src     = instr[SRC_LSB +: REG_W];
    assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, instr[IMM_W-1:0]};
    assign active  = (phase == PH_DECODE) || (phase == PH_EXEC);
    assign in_exec = (phase == PH_EXEC);
    assign out_en  = 1'b0;

    // Opcode to control mapping; unknown opcodes keep all defaults (R11).
    always_comb begin
        rd_addr_a = '0;
        rd_addr_b = '0;
        wr_addr   = '0;
        rd_en_a   = 1'b0;
        rd_en_b   = 1'b0;
        wr_en     = 1'b0;
        alu_op    = ALU_PASS;
        mux_sel   = SRC_IMM;
        imm_out   = '0;
        case (opc)
            OP_MOVI: begin
                imm_out = imm_ext;
                wr_addr = dst;
                wr_en   = in_exec;
            end
            OP_MOVR: begin
                rd_addr_b = src;
                rd_en_b   = active;
                wr_addr   = dst;
                wr_en     = in_exec;
                mux_sel   = SRC_PORTB;
            end
            OP_ADDR: begin
                rd_addr_a = dst;
                rd_addr_b = src;
                rd_en_a   = active;
                rd_en_b   = active;
                wr_addr   = dst;
                wr_en     = in_exec;
                alu_op    = ALU_SUM;
                mux_sel   = SRC_ALU;
            end
            OP_ADDI: begin
                imm_out   = imm_ext;
                rd_addr_a = dst;
                rd_en_a   = active;
                wr_addr   = dst;
                wr_en     = in_exec;
                alu_op    = ALU_SUM;
                mux_sel   = SRC_ALU;
            end
            default: ;
        endcase
    end

    // R8: write is a single-cycle pulse
    a_r8_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R8: write only follows a decode period
    a_r8_wr_after_decode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(phase) == PH_DECODE);
    // R9: quiet in fetch
    a_r9_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FETCH |-> !(rd_en_a || rd_en_b || wr_en));
    // R10: controls identical in decode and execute
    a_r10_stable_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_EXEC |-> $stable({rd_addr_a, rd_addr_b, wr_addr, rd_en_a,
                                      rd_en_b, alu_op, mux_sel, imm_out}));
endmodule

// File: rtl/ctl_unit.sv
// Module: ctl_unit (top)
// Three-phase instruction control unit: sequencer, instruction register
// and decoder. Assumes instruction words arrive on mem_word during fetch.
module ctl_unit
    import ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  mem_word,
    output logic [REG_W-1:0]    rd_addr_a,
    output logic [REG_W-1:0]    rd_addr_b,
    output logic [REG_W-1:0]    wr_addr,
    output logic                rd_en_a,
    output logic                rd_en_b,
    output logic                wr_en,
    output logic [ALU_W-1:0]    alu_op,
    output logic [MUX_W-1:0]    mux_sel,
    output logic [DATA_W-1:0]   imm_out,
    output logic                out_en
);
    phase_e             phase;
    logic [INSTR_W-1:0] instr;

    ctl_sequencer u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    ctl_ireg #(.W(INSTR_W)) u_ireg (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .mem_word (mem_word),
        .instr    (instr)
    );

    ctl_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .instr     (instr),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .wr_addr   (wr_addr),
        .rd_en_a   (rd_en_a),
        .rd_en_b   (rd_en_b),
        .wr_en     (wr_en),
        .alu_op    (alu_op),
        .mux_sel   (mux_sel),
        .imm_out   (imm_out),
        .out_en    (out_en)
    );

    // R11: an unknown opcode in decode still reaches fetch two cycles later
    a_r11_unknown_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && instr[INSTR_W-1 -: OPC_W] > OP_ADDI) |=> !wr_en && phase == PH_FETCH);
endmodule

// File: tb/test_ctl_unit.sv
`timescale 1ns/1ps
module test_ctl_unit;
    localparam real TCK = 8.0;

    typedef struct packed {
        logic [31:0] word;
        logic [3:0]  ea;
        logic [3:0]  eb;
        logic [3:0]  ew;
        logic [1:0]  alu;
        logic [1:0]  mux;
        logic [31:0] imm;
        logic        ra;
        logic        rb;
        logic        w;
    } vec_t;

    // word, rdA, rdB, wr, alu, mux, imm, rdenA, rdenB, wren
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{{6'h00, 4'd0, 22'd10},         4'd0, 4'd0, 4'd0, 2'd0, 2'd0, 32'd10, 1'b0, 1'b0, 1'b1},
        '{{6'h00, 4'd1, 22'd20},         4'd0, 4'd0, 4'd1, 2'd0, 2'd0, 32'd20, 1'b0, 1'b0, 1'b1},
        '{{6'h01, 4'd2, 4'd1, 18'd0},    4'd0, 4'd1, 4'd2, 2'd0, 2'd1, 32'd0,  1'b0, 1'b1, 1'b1},
        '{{6'h02, 4'd2, 4'd0, 18'd0},    4'd2, 4'd0, 4'd2, 2'd1, 2'd2, 32'd0,  1'b1, 1'b1, 1'b1},
        '{{6'h03, 4'd2, 22'd2},          4'd2, 4'd0, 4'd2, 2'd1, 2'd2, 32'd2,  1'b1, 1'b0, 1'b1},
        '{{6'h00, 4'd15, 22'h3FFFFF},    4'd0, 4'd0, 4'd15, 2'd0, 2'd0, 32'h003FFFFF, 1'b0, 1'b0, 1'b1},
        '{{6'h3F, 4'd5, 22'h12345},      4'd0, 4'd0, 4'd0, 2'd0, 2'd0, 32'd0,  1'b0, 1'b0, 1'b0},
        '{{6'h02, 4'd15, 4'd14, 18'd0},  4'd15, 4'd14, 4'd15, 2'd1, 2'd2, 32'd0, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_word = '0;
    logic [3:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic        rd_en_a, rd_en_b, wr_en, out_en;
    logic [1:0]  alu_op, mux_sel;
    logic [31:0] imm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(TCK/2) clk = ~clk;

    ctl_unit i_ctl_unit (
        .clk(clk), .rst_n(rst_n), .mem_word(mem_word),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .wr_addr(wr_addr),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .wr_en(wr_en),
        .alu_op(alu_op), .mux_sel(mux_sel), .imm_out(imm_out), .out_en(out_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            6'h00: return "R4";
            6'h01: return "R5";
            6'h02: return "R6";
            6'h03: return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [63:0] data_now();
        return {rd_addr_a, rd_addr_b, wr_addr, alu_op, mux_sel, imm_out};
    endfunction

    function automatic logic [63:0] data_exp(input vec_t v);
        return {v.ea, v.eb, v.ew, v.alu, v.mux, v.imm};
    endfunction

    initial begin
        // Reset state (R1, R12)
        rst_n = 1'b0;
        tick(); tick();
        chk("R1 enables low in reset", {rd_en_a, rd_en_b, wr_en}, 0);
        chk("R12 out_en disabled", out_en, 0);
        rst_n = 1'b1;

        // Table walk: R3 field layout, R4-R7, R11 decode; R2/R8/R9/R10 timing
        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            string t = tag_of(v.word[31:26]);
            mem_word = v.word;           // fetch period
            chk("R9 fetch enables low", {rd_en_a, rd_en_b, wr_en}, 0);
            tick();                      // now decode
            mem_word = ~v.word;          // R10: must be ignored
            chk({t, " R3 decode fields"}, data_now(), data_exp(v));
            chk({t, " R9 decode read enables"}, {rd_en_a, rd_en_b, wr_en}, {v.ra, v.rb, 1'b0});
            tick();                      // now execute
            chk({t, " R10 execute fields"}, data_now(), data_exp(v));
            chk({t, " R8 execute enables"}, {rd_en_a, rd_en_b, wr_en}, {v.ra, v.rb, v.w});
            chk("R12 out_en disabled", out_en, 0);
            tick();                      // back in fetch (R2)
            chk({t, " R2 R8 back to fetch"}, {rd_en_a, rd_en_b, wr_en}, 0);
        end

        // Directed: reset during decode meets the fetch latch (R1, R10)
        mem_word = {6'h02, 4'd7, 4'd3, 18'd0};
        tick();                          // decode of add-register
        chk("R6 decode before reset", {rd_en_a, rd_en_b}, 2'b11);
        rst_n = 1'b0;
        mem_word = {6'h01, 4'd9, 4'd4, 18'd0};
        tick();                          // reset edge: fetch, no write
        chk("R1 reset in decode gives fetch", {rd_en_a, rd_en_b, wr_en}, 0);
        rst_n = 1'b1;
        tick();                          // latched move-register, decode
        chk("R1 first decode after reset", {rd_en_a, rd_en_b, wr_en, rd_addr_b, wr_addr, mux_sel},
            {1'b0, 1'b1, 1'b0, 4'd4, 4'd9, 2'd1});
        tick();
        chk("R2 execute after reset", wr_en, 1);
        tick();
        chk("R8 pulse ended", wr_en, 0);

        // Directed: unknown opcode with all payload bits set (R11)
        mem_word = 32'hFFFF_FFFF;
        tick();
        chk("R11 unknown decode", {data_now(), rd_en_a, rd_en_b, wr_en}, 0);
        tick();
        chk("R11 unknown execute", {data_now(), rd_en_a, rd_en_b, wr_en}, 0);
        mem_word = {6'h00, 4'd3, 22'd5};
        tick();                          // fetch
        tick();                          // decode of move-immediate
        chk("R11 sequencer resumed", {wr_addr, imm_out}, {4'd3, 32'd5});
        tick();
        chk("R11 write after recovery", wr_en, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(TCK * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule